// File: doc/BRIEF.md
# Wormhole Crossbar Switching Element

This block is one switching stage for an event-building network. It has eight input links and eight output links joined by a full crossbar. Each packet carries its own path. The first byte to arrive on an idle input is a route byte. The switch consumes that byte, uses its low three bits to pick an output, and never forwards it. The stage after this one therefore sees its own route byte at the head of the packet.

Once an input wins its output, the connection stays in place until the packet's tail flit has crossed. This is wormhole switching. The switch stores no packets. Payload flits pass combinationally from the owning input to its output, and a stop from downstream (`out_xoff`) reaches the owning input's `in_xoff` in the same cycle. An input that is waiting for an output holds its sender with `in_xoff`. When several inputs contend for one free output, a round-robin arbiter for that output decides.

Each input runs a state machine:
- `IN_IDLE` moves to `IN_WAIT` when a route byte without tail is accepted.
- `IN_WAIT` moves to `IN_PASS` on a grant.
- `IN_PASS` moves back to `IN_IDLE` when the tail flit is transferred.
- A route byte that carries tail keeps the input in `IN_IDLE`.

Each output arbiter runs a state machine:
- `ARB_FREE` moves to `ARB_HELD` when it grants.
- `ARB_HELD` moves back to `ARB_FREE` when its owner's tail is transferred.

Top module: `wh_xbar_switch`

## Requirements
- R1: While reset is held and right after it, every `in_xoff` is 0, every `out_valid` is 0 and every output is free.
- R2: On an idle input, the first valid flit is a route byte. It is accepted (its `in_xoff` is 0) and is never forwarded. Bits [2:0] select output 0..7, and bits [7:3] have no effect.
- R3: On a connected path, `out_valid`, `out_data` and `out_tail` of the output equal the owning input's `in_valid`, `in_data` and `in_tail` in the same cycle. A flit moves when valid is 1 and xoff is 0 at a clock edge.
- R4: While an output is held, no other input reaches it. A contender keeps `in_xoff` at 1 and never appears on that output before the tail of the current packet.
- R5: An output becomes free in the cycle after its tail is transferred, and arbitrates in that cycle. A waiting input is connected in the next cycle. A free output drives `out_valid` 0.
- R6: Each output keeps a round-robin pointer. After it grants input i, the search for the next grant starts at input i+1, wrapping from 7 to 0.
- R7: `out_xoff` of a held output appears on the owner's `in_xoff` in the same cycle. No flit is lost or duplicated while a link stalls.
- R8: An input that has a route but no grant holds `in_xoff` at 1. Its route byte is accepted in the cycle before this starts, and the path can open two cycles after that acceptance.
- R9: A route byte with tail set is dropped. The input stays idle, and nothing appears on any output.
- R10: Packets from several inputs to distinct outputs flow at the same time. Every packet arrives whole, in order and at the output its route byte named.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Flit present on each input link |
| in_tail | input | 8 | Flit is the last of its packet, per input |
| in_data | input | 64 | Flit byte per input, input i at bits [8i+7:8i] |
| in_xoff | output | 8 | Stop sent back to each upstream sender |
| out_valid | output | 8 | Flit present on each output link |
| out_tail | output | 8 | Output flit is the last of its packet |
| out_data | output | 64 | Flit byte per output, output o at bits [8o+7:8o] |
| out_xoff | input | 8 | Stop from each downstream receiver |

## Verification
The assertions check on every cycle that:
- a held output has exactly one connected input;
- a free output is silent;
- the output is released right after its tail;
- a downstream stop reaches the owner;
- a waiting input stalls its sender.

The bench's scenarios are needed for what depends on history. These are the exact cycle at which a path opens, the rotation of the round-robin order, the dropping of tail-only route bytes, and the delivery of whole packets under random stalls with none lost or duplicated.

// File: rtl/wh_xbar_pkg.sv
package wh_xbar_pkg;
    typedef enum logic [1:0] {
        IN_IDLE = 2'd0,
        IN_WAIT = 2'd1,
        IN_PASS = 2'd2
    } in_state_e;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/wh_in_port.sv
module wh_in_port
    import wh_xbar_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_tail,
    input  logic [DW-1:0]   in_data,
    input  logic            grant,
    input  logic            dn_xoff,
    output logic            in_xoff,
    output logic            req,
    output logic            connected,
    output logic            tail_done,
    output logic [SELW-1:0] dest
);
    in_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IN_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dest <= '0;
        else if (state == IN_IDLE && in_valid)
            dest <= in_data[SELW-1:0];
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IN_IDLE: if (in_valid && !in_tail) state_nx = IN_WAIT;
            IN_WAIT: if (grant) state_nx = IN_PASS;
            IN_PASS: if (in_valid && !dn_xoff && in_tail) state_nx = IN_IDLE;
            default: state_nx = IN_IDLE;
        endcase
    end

    always_comb begin
        in_xoff   = 1'b0;
        req       = 1'b0;
        connected = 1'b0;
        tail_done = 1'b0;
        unique case (state)
            IN_IDLE: in_xoff = 1'b0;
            IN_WAIT: begin
                in_xoff = 1'b1;
                req     = 1'b1;
            end
            IN_PASS: begin
                in_xoff   = dn_xoff;
                connected = 1'b1;
                tail_done = in_valid && !dn_xoff && in_tail;
            end
            default: in_xoff = 1'b0;
        endcase
    end
endmodule

// File: rtl/wh_out_arb.sv
module wh_out_arb
    import wh_xbar_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic            release_path,
    output logic [N-1:0]    gnt,
    output logic            busy,
    output logic [IDXW-1:0] owner
);
    arb_state_e      state, state_nx;
    logic [IDXW-1:0] rr_ptr;
    logic [IDXW-1:0] pick;
    logic [IDXW:0]   probe;
    logic            found;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARB_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        pick  = '0;
        probe = '0;
        if (state == ARB_FREE) begin
            for (int k = 0; k < N; k++) begin
                probe = {1'b0, rr_ptr} + (IDXW+1)'(k);
                if (probe >= (IDXW+1)'(N)) probe = probe - (IDXW+1)'(N);
                if (!found && req[probe[IDXW-1:0]]) begin
                    found = 1'b1;
                    pick  = probe[IDXW-1:0];
                end
            end
            if (found) gnt[pick] = 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_FREE: if (found) state_nx = ARB_HELD;
            ARB_HELD: if (release_path) state_nx = ARB_FREE;
            default:  state_nx = ARB_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner  <= '0;
            rr_ptr <= '0;
        end else if (state == ARB_FREE && found) begin
            owner  <= pick;
            rr_ptr <= (pick == IDXW'(N-1)) ? '0 : pick + 1'b1;
        end
    end

    assign busy = (state == ARB_HELD);
endmodule

// File: rtl/wh_xbar_switch.sv
module wh_xbar_switch #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_valid,
    input  logic [N-1:0]    in_tail,
    input  logic [N*DW-1:0] in_data,
    output logic [N-1:0]    in_xoff,
    output logic [N-1:0]    out_valid,
    output logic [N-1:0]    out_tail,
    output logic [N*DW-1:0] out_data,
    input  logic [N-1:0]    out_xoff
);
    localparam int SELW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]      req_w, conn_w, tdone_w, grant_w, busy_w;
    logic [N*SELW-1:0] dest_w, owner_w;
    logic [N-1:0]      gnt_by_out [N];
    logic [N-1:0]      req_by_out [N];

    for (genvar i = 0; i < N; i++) begin : g_in
        wh_in_port #(.DW(DW), .SELW(SELW)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[i]),
            .in_tail   (in_tail[i]),
            .in_data   (in_data[i*DW +: DW]),
            .grant     (grant_w[i]),
            .dn_xoff   (out_xoff[dest_w[i*SELW +: SELW]]),
            .in_xoff   (in_xoff[i]),
            .req       (req_w[i]),
            .connected (conn_w[i]),
            .tail_done (tdone_w[i]),
            .dest      (dest_w[i*SELW +: SELW])
        );
    end

    always_comb begin
        grant_w = '0;
        for (int o = 0; o < N; o++) grant_w = grant_w | gnt_by_out[o];
    end

    for (genvar o = 0; o < N; o++) begin : g_out
        localparam int unsigned OI = o;
        logic [SELW-1:0] own;

        for (genvar i = 0; i < N; i++) begin : g_req
            assign req_by_out[o][i] = req_w[i] && (dest_w[i*SELW +: SELW] == OI[SELW-1:0]);
        end

        wh_out_arb #(.N(N), .IDXW(SELW)) u_arb (
            .clk          (clk),
            .rst_n        (rst_n),
            .req          (req_by_out[o]),
            .release_path (busy_w[o] && tdone_w[own]),
            .gnt          (gnt_by_out[o]),
            .busy         (busy_w[o]),
            .owner        (own)
        );

        assign owner_w[o*SELW +: SELW] = own;
        assign out_valid[o]            = busy_w[o] && in_valid[own];
        assign out_tail[o]             = busy_w[o] && in_tail[own];
        assign out_data[o*DW +: DW]    = busy_w[o] ? in_data[own*DW +: DW] : '0;
    end
endmodule

// File: rtl/wh_xbar_checker.sv
module wh_xbar_checker #(
    parameter int N    = 8,
    parameter int DW   = 8,
    parameter int SELW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    in_valid,
    input logic [N*DW-1:0] in_data,
    input logic [N-1:0]    in_xoff,
    input logic [N-1:0]    out_valid,
    input logic [N-1:0]    out_tail,
    input logic [N*DW-1:0] out_data,
    input logic [N-1:0]    out_xoff,
    input logic [N-1:0]    conn,
    input logic [N-1:0]    waiting,
    input logic [N-1:0]    busy,
    input logic [N*SELW-1:0] dest_flat,
    input logic [N*SELW-1:0] owner_flat
);
    for (genvar i = 0; i < N; i++) begin : g_ci
        assert_wait_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            waiting[i] |-> in_xoff[i]);
    end

    for (genvar o = 0; o < N; o++) begin : g_co
        localparam int unsigned OI = o;
        logic [N-1:0]    cmask;
        logic [SELW-1:0] own;
        assign own = owner_flat[o*SELW +: SELW];

        always_comb begin
            for (int i = 0; i < N; i++)
                cmask[i] = conn[i] && (dest_flat[i*SELW +: SELW] == OI[SELW-1:0]);
        end

        assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
            busy[o] |-> ($countones(cmask) == 1) && cmask[own]);

        assert_free_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[o] |-> !out_valid[o]);

        assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && out_tail[o] && !out_xoff[o]) |=> !busy[o]);

        assert_pass_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> in_valid[own] && out_data[o*DW +: DW] == in_data[own*DW +: DW]);

        assert_xoff_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[o] && out_xoff[o]) |-> in_xoff[own]);
    end
endmodule

bind wh_xbar_switch wh_xbar_checker #(.N(N), .DW(DW), .SELW(SELW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_xoff    (in_xoff),
    .out_valid  (out_valid),
    .out_tail   (out_tail),
    .out_data   (out_data),
    .out_xoff   (out_xoff),
    .conn       (conn_w),
    .waiting    (req_w),
    .busy       (busy_w),
    .dest_flat  (dest_w),
    .owner_flat (owner_w)
);

// File: tb/wh_xbar_switch_tb.sv
module wh_xbar_switch_tb;
    localparam int N = 8;
    localparam int DW = 8;
    localparam int PKTS = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    in_valid, in_tail, in_xoff, out_valid, out_tail, out_xoff;
    logic [N*DW-1:0] in_data, out_data;

    logic       tv [N];
    logic       tt [N];
    logic [7:0] td [N];
    logic [7:0] route_of [N][32];

    int checks = 0, errors = 0, tx_pkts = 0, rx_pkts = 0;
    bit rnd_xoff = 0, mon_en = 0, done = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_valid[i]          = tv[i];
            in_tail[i]           = tt[i];
            in_data[i*DW +: DW]  = td[i];
        end
    end

    wh_xbar_switch #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tail(in_tail),
        .in_data(in_data), .in_xoff(in_xoff), .out_valid(out_valid),
        .out_tail(out_tail), .out_data(out_data), .out_xoff(out_xoff)
    );

    function automatic int pkt_len(int s, int k);
        return 1 + ((s + k) % 4);
    endfunction

    function automatic logic [7:0] pay_byte(int s, int k, int j);
        if (j == 0) return {3'(s), 5'(k)};
        return 8'((s * 29 + k * 13 + j * 7) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic drv(int s, bit v, bit t, logic [7:0] d);
        tv[s] = v; tt[s] = t; td[s] = d;
    endtask

    task automatic send_pkt(int s, int k);
        int len = pkt_len(s, k);
        bit acc;
        for (int f = 0; f <= len; f++) begin
            if (f == 0) drv(s, 1'b1, 1'b0, route_of[s][k]);
            else        drv(s, 1'b1, f == len, pay_byte(s, k, f - 1));
            do begin
                #2;
                acc = !in_xoff[s];
                cyc();
            end while (!acc);
        end
        drv(s, 1'b0, 1'b0, 8'h00);
        tx_pkts++;
    endtask

    task automatic src_run(int s);
        for (int k = 0; k < PKTS; k++) begin
            route_of[s][k] = 8'($urandom);
            send_pkt(s, k);
            repeat ($urandom % 3) cyc();
        end
    endtask

    task automatic mon_run(int o);
        int idx = 0, s = 0, k = 0, len = 0;
        forever begin
            @(posedge clk);
            #3;
            if (mon_en && out_valid[o] && !out_xoff[o]) begin
                if (idx == 0) begin
                    s = int'(out_data[o*DW + 5 +: 3]);
                    k = int'(out_data[o*DW +: 5]);
                    len = pkt_len(s, k);
                    chk(int'(route_of[s][k][2:0]) == o, "R2 output from route bits",
                        o, int'(route_of[s][k][2:0]));
                end else begin
                    chk(out_data[o*DW +: DW] == pay_byte(s, k, idx), "R7 flit order",
                        int'(out_data[o*DW +: DW]), int'(pay_byte(s, k, idx)));
                end
                chk(out_tail[o] == (idx == len - 1), "R10 tail position",
                    int'(out_tail[o]), int'(idx == len - 1));
                if (out_tail[o]) begin
                    idx = 0;
                    rx_pkts++;
                end else idx++;
            end
        end
    endtask

    initial begin
        for (int o = 0; o < N; o++) begin
            automatic int oo = o;
            fork mon_run(oo); join_none
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rnd_xoff) out_xoff = N'($urandom) & N'($urandom);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", rx_pkts, tx_pkts);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) drv(i, 1'b0, 1'b0, 8'h00);
        out_xoff = '0;
        repeat (3) cyc();
        #2;
        chk(in_xoff == '0, "R1 xoff in reset", int'(in_xoff), 0);
        chk(out_valid == '0, "R1 valid in reset", int'(out_valid), 0);
        cyc();
        rst_n = 1'b1;
        cyc();

        // R2 / R8 / R3: route 0xF3 from input 0 lands on output 3
        drv(0, 1, 0, 8'hF3);
        #2; chk(in_xoff[0] == 0, "R2 route byte accepted", int'(in_xoff[0]), 0);
        cyc(); drv(0, 1, 0, 8'hA5);
        #2; chk(in_xoff[0] == 1, "R8 stall while waiting", int'(in_xoff[0]), 1);
        chk(out_valid == '0, "R2 route byte not forwarded", int'(out_valid), 0);
        cyc();
        #2; chk(out_valid == 8'h08, "R2 upper bits ignored", int'(out_valid), 8);
        chk(out_data[24 +: 8] == 8'hA5, "R3 payload passes", int'(out_data[24 +: 8]), 'hA5);
        cyc(); drv(0, 1, 1, 8'h5A);
        #2; chk(out_tail[3] && out_data[24 +: 8] == 8'h5A, "R3 tail passes",
                int'(out_data[24 +: 8]), 'h5A);
        cyc(); drv(0, 0, 0, 8'h00);
        #2; chk(out_valid == '0, "R5 released after tail", int'(out_valid), 0);
        cyc();

        // R7: downstream stop on output 3 with input 1
        drv(1, 1, 0, 8'h0B); cyc();
        drv(1, 1, 0, 8'h11); cyc();
        out_xoff[3] = 1'b1;
        #2; chk(in_xoff[1] == 1 && out_valid[3], "R7 stop reaches owner", int'(in_xoff[1]), 1);
        cyc(); out_xoff[3] = 1'b0;
        #2; chk(in_xoff[1] == 0 && out_data[24 +: 8] == 8'h11, "R7 held flit",
                int'(out_data[24 +: 8]), 'h11);
        cyc(); drv(1, 1, 1, 8'h12);
        #2; chk(out_data[24 +: 8] == 8'h12, "R7 no duplicate", int'(out_data[24 +: 8]), 'h12);
        cyc(); drv(1, 0, 0, 8'h00); cyc();

        // R6 / R4 / R5: input 2 alone first, then 2 and 5 contend for output 4
        drv(2, 1, 0, 8'h04); cyc();
        drv(2, 1, 1, 8'h20); cyc(); cyc();
        drv(2, 0, 0, 8'h00); cyc();
        drv(2, 1, 0, 8'h04); drv(5, 1, 0, 8'hC4); cyc();
        drv(2, 1, 1, 8'h22); drv(5, 1, 1, 8'h55);
        #2; chk(in_xoff[2] && in_xoff[5], "R8 both waiting", int'(in_xoff), 'h24);
        cyc();
        #2; chk(!in_xoff[5] && out_data[32 +: 8] == 8'h55, "R6 rotation picks input 5",
                int'(out_data[32 +: 8]), 'h55);
        chk(in_xoff[2] == 1, "R4 loser stalled", int'(in_xoff[2]), 1);
        cyc(); drv(5, 0, 0, 8'h00);
        #2; chk(in_xoff[2] == 1 && !out_valid[4], "R5 release cycle", int'(in_xoff[2]), 1);
        cyc();
        #2; chk(!in_xoff[2] && out_data[32 +: 8] == 8'h22, "R5 waiter connected",
                int'(out_data[32 +: 8]), 'h22);
        cyc(); drv(2, 0, 0, 8'h00); cyc();

        // R9: tail-only route byte on input 6 is dropped
        drv(6, 1, 1, 8'h07);
        #2; chk(in_xoff[6] == 0, "R9 dropped byte accepted", int'(in_xoff[6]), 0);
        cyc(); drv(6, 0, 0, 8'h00);
        #2; chk(in_xoff[6] == 0 && out_valid == '0, "R9 input stays idle", int'(out_valid), 0);
        cyc(); drv(6, 1, 0, 8'h07); cyc();
        drv(6, 1, 1, 8'h77); cyc();
        #2; chk(out_valid == 8'h80 && out_data[56 +: 8] == 8'h77, "R9 next packet normal",
                int'(out_data[56 +: 8]), 'h77);
        cyc(); drv(6, 0, 0, 8'h00); cyc(); cyc();

        // R10: random traffic on all inputs with random stops
        mon_en = 1; rnd_xoff = 1;
        for (int s = 0; s < N; s++) begin
            automatic int ss = s;
            fork src_run(ss); join_none
        end
        wait (tx_pkts == N * PKTS);
        rnd_xoff = 0; out_xoff = '0;
        repeat (10) cyc();
        chk(rx_pkts == tx_pkts, "R10 all packets delivered", rx_pkts, tx_pkts);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule